// File: doc/BRIEF.md
# Lane-Splittable Vector ALU

This block is a registered 32-bit arithmetic and logic unit whose datapath can be cut into independent lanes. One operation runs as a single 32-bit lane, as two 16-bit lanes or as four 8-bit lanes. No carry crosses a lane boundary, and every lane produces its own negative, carry, zero and overflow flags. The lane flags are packed into a 16-bit vector flag field, and a set of legacy summary flags reports whether any active lane raised a given flag.

For redundant computation, software copies one operand value into every lane and runs a split operation. The block then reports whether all lane results agree. If they differ while fault detection is enabled, it raises an interrupt request. A split width is only legal when the destination register index is below 8. An illegal request raises an error pulse and leaves all held state untouched.

Top module: `vec_alu`

## Requirements
- R1: One operation is accepted per clock in which `op_valid` is high. The result register updates on that edge. `lane_mode` is 0 for one 32-bit lane, 1 for two 16-bit lanes and 2 for four 8-bit lanes. `op_code` is 0 ADD, 1 ADC, 2 SUB (a + ~b + 1), 3 AND, 4 OR and 5 XOR. Each lane computes on its own bits, and no carry passes from one lane to the next.
- R2: Each active lane produces N (the top result bit of the lane), C (the carry out of the lane), Z (the lane result is zero) and V (the sign bits of both operands agree and differ from the sign bit of the result).
- R3: `vec_flags` holds C in [15:12], V in [11:8], Z in [7:4] and N in [3:0]. Bit i of each nibble belongs to byte lane i, and a lane's flags are kept at the position of its top byte. This puts flags at lane 3 only in 32-bit mode and at lanes 1 and 3 in 16-bit mode. All other flag bits read 0.
- R4: Each of `sum_n`, `sum_c`, `sum_z` and `sum_v` is the OR of that flag over the active lanes.
- R5: `lanes_equal` is 1 when all four bytes of the result match in 8-bit mode, or when both halves match in 16-bit mode. It is always 1 in 32-bit mode.
- R6: On an accepted operation, `fault_irq` becomes `fault_en` AND NOT lanes-equal. It holds that value until the next accepted operation.
- R7: A request for 16-bit or 8-bit mode with `dest_idx` of 8 or above is illegal.
- R8: Logical operations (AND, OR, XOR) clear C and V in every lane.
- R9: The following requests are also illegal: `lane_mode` 3, and `op_code` 6 or 7. For any illegal request, `width_err` is high for exactly the one cycle after the request. The result, the flags, `lanes_equal` and `fault_irq` keep their previous values.
- R10: ADC adds the summary carry `sum_c` of the previous accepted operation as the carry-in to every lane. SUB uses a carry-in of 1, so C=1 means no borrow occurred.
- R11: After reset, the result and all flags are 0, `lanes_equal` is 1, and `fault_irq` and `width_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Accept the operation presented this cycle |
| op_code | input | 3 | Operation select |
| lane_mode | input | 2 | Lane width select |
| dest_idx | input | 4 | Destination register index |
| fault_en | input | 1 | Enables the lane-mismatch interrupt |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| result | output | 32 | Registered result |
| vec_flags | output | 16 | Per-lane C, V, Z, N flags |
| sum_n | output | 1 | OR of active lane N flags |
| sum_c | output | 1 | OR of active lane C flags |
| sum_z | output | 1 | OR of active lane Z flags |
| sum_v | output | 1 | OR of active lane V flags |
| lanes_equal | output | 1 | All lane results identical |
| fault_irq | output | 1 | Lane-mismatch interrupt request |
| width_err | output | 1 | Illegal request pulse |

## Verification
The hardest case to reach from the ports is a mismatch between lanes that should have agreed. Operands duplicated across lanes always give equal results, so the interrupt path is never exercised by them alone. To reach it, the stimulus includes duplicated-operand pairs with a single byte or halfword altered by one bit. These pairs are swept across every lane mode, opcode, destination index and enable setting. Boundary operands such as all-ones plus one and 0x7F plus 1 in every byte test the lane carry cut and the per-lane overflow. ADC is placed in the sweep right after operations that leave the summary carry set.

// File: rtl/vec_alu.sv
module vec_alu #(
  parameter int IDX_W = 4,
  parameter int SPLIT_LIMIT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [2:0]       op_code,
  input  logic [1:0]       lane_mode,
  input  logic [IDX_W-1:0] dest_idx,
  input  logic             fault_en,
  input  logic [31:0]      opnd_a,
  input  logic [31:0]      opnd_b,
  output logic [31:0]      result,
  output logic [15:0]      vec_flags,
  output logic             sum_n,
  output logic             sum_c,
  output logic             sum_z,
  output logic             sum_v,
  output logic             lanes_equal,
  output logic             fault_irq,
  output logic             width_err
);
  localparam int LANES = 4;

  logic [LANES-1:0] first_lane, top_lane, byte_zero, lane_ovf, grp_zero;
  logic [LANES:0]   chain;
  logic [31:0]      b_eff, sum_w, logic_w, res_d;
  logic             is_arith, is_sub, base_cin, legal, eq_d;
  logic [15:0]      flags_d;

  always_comb begin
    case (lane_mode)
      2'd0:    begin first_lane = 4'b0001; top_lane = 4'b1000; end
      2'd1:    begin first_lane = 4'b0101; top_lane = 4'b1010; end
      default: begin first_lane = 4'b1111; top_lane = 4'b1111; end
    endcase
  end

  assign is_arith = op_code <= 3'd2;
  assign is_sub   = op_code == 3'd2;
  assign base_cin = (op_code == 3'd1) ? sum_c : is_sub;
  assign b_eff    = is_sub ? ~opnd_b : opnd_b;
  assign chain[0] = base_cin;

  assign legal = (lane_mode != 2'd3) && (op_code < 3'd6) &&
                 ((lane_mode == 2'd0) || (dest_idx < IDX_W'(SPLIT_LIMIT)));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic cin;
    logic [8:0] s9;
    assign cin = first_lane[i] ? base_cin : chain[i];
    assign s9 = {1'b0, opnd_a[8*i +: 8]} + {1'b0, b_eff[8*i +: 8]} + 9'(cin);
    assign sum_w[8*i +: 8] = s9[7:0];
    assign chain[i+1] = s9[8];
    assign lane_ovf[i] = (opnd_a[8*i+7] == b_eff[8*i+7]) && (s9[7] != opnd_a[8*i+7]);
    assign byte_zero[i] = res_d[8*i +: 8] == 8'd0;
  end

  always_comb begin
    case (op_code)
      3'd3:    logic_w = opnd_a & opnd_b;
      3'd4:    logic_w = opnd_a | opnd_b;
      default: logic_w = opnd_a ^ opnd_b;
    endcase
  end

  assign res_d = is_arith ? sum_w : logic_w;

  always_comb begin
    case (lane_mode)
      2'd0:    grp_zero = {4{&byte_zero}};
      2'd1:    grp_zero = {{2{&byte_zero[3:2]}}, {2{&byte_zero[1:0]}}};
      default: grp_zero = byte_zero;
    endcase
  end

  assign flags_d[15:12] = is_arith ? (top_lane & chain[LANES:1]) : 4'd0;
  assign flags_d[11:8]  = is_arith ? (top_lane & lane_ovf) : 4'd0;
  assign flags_d[7:4]   = top_lane & grp_zero;
  assign flags_d[3:0]   = top_lane & {res_d[31], res_d[23], res_d[15], res_d[7]};

  always_comb begin
    case (lane_mode)
      2'd1:    eq_d = res_d[31:16] == res_d[15:0];
      2'd2:    eq_d = (res_d[31:24] == res_d[7:0]) && (res_d[23:16] == res_d[7:0]) &&
                      (res_d[15:8] == res_d[7:0]);
      default: eq_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result      <= '0;
      vec_flags   <= '0;
      lanes_equal <= 1'b1;
      fault_irq   <= 1'b0;
      width_err   <= 1'b0;
    end else begin
      width_err <= op_valid && !legal;
      if (op_valid && legal) begin
        result      <= res_d;
        vec_flags   <= flags_d;
        lanes_equal <= eq_d;
        fault_irq   <= fault_en && !eq_d;
      end
    end
  end

  assign sum_c = |vec_flags[15:12];
  assign sum_v = |vec_flags[11:8];
  assign sum_z = |vec_flags[7:4];
  assign sum_n = |vec_flags[3:0];
endmodule

// File: rtl/vec_alu_chk.sv
module vec_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [2:0]  op_code,
  input logic [1:0]  lane_mode,
  input logic [3:0]  dest_idx,
  input logic [31:0] result,
  input logic [15:0] vec_flags,
  input logic        sum_c,
  input logic        sum_v,
  input logic        lanes_equal,
  input logic        fault_irq,
  input logic        width_err
);
  AST_ERR_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    width_err |-> $stable(result) && $stable(vec_flags) && $stable(lanes_equal)); // R9
  AST_SPLIT_DEST_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && lane_mode != 2'd0 && dest_idx >= 4'd8) |=> width_err); // R7
  AST_WIDE_FLAG_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && lane_mode == 2'd0 && op_code < 3'd6) |=> (vec_flags & 16'h7777) == 16'h0); // R3
  AST_WIDE_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && lane_mode == 2'd0 && op_code < 3'd6) |=> lanes_equal); // R5
  AST_IRQ_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    fault_irq |-> !lanes_equal); // R6
  AST_LOGIC_NO_CV: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code >= 3'd3 && op_code <= 3'd5 && lane_mode == 2'd0) |=> !sum_c && !sum_v); // R8
endmodule

bind vec_alu vec_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .lane_mode(lane_mode), .dest_idx(dest_idx), .result(result),
  .vec_flags(vec_flags), .sum_c(sum_c), .sum_v(sum_v),
  .lanes_equal(lanes_equal), .fault_irq(fault_irq), .width_err(width_err)
);

// File: tb/vec_alu_test.sv
module vec_alu_test;
  logic clk = 1'b0, rst_n = 1'b0, op_valid = 1'b0, fault_en = 1'b0;
  logic [2:0] op_code = '0;
  logic [1:0] lane_mode = '0;
  logic [3:0] dest_idx = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [31:0] result;
  logic [15:0] vec_flags;
  logic sum_n, sum_c, sum_z, sum_v, lanes_equal, fault_irq, width_err;
  int total = 0, bad = 0;

  logic [31:0] e_res = '0;
  logic [15:0] e_vf = '0;
  logic e_eq = 1'b1, e_irq = 1'b0, e_err = 1'b0;

  always #2 clk = ~clk;

  vec_alu uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .lane_mode(lane_mode), .dest_idx(dest_idx), .fault_en(fault_en),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .vec_flags(vec_flags),
    .sum_n(sum_n), .sum_c(sum_c), .sum_z(sum_z), .sum_v(sum_v),
    .lanes_equal(lanes_equal), .fault_irq(fault_irq), .width_err(width_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat_a(input int k);
    case (k)
      0: return 32'h0000_0000;  1: return 32'hFFFF_FFFF;
      2: return 32'h7F7F_7F7F;  3: return 32'h8080_8080;
      4: return 32'h1234_5678;  5: return 32'h3C3C_3C3C;
      6: return 32'h3C3C_3D3C;  7: return 32'hABCD_ABCD;
      8: return 32'hABCD_ABCC;  default: return 32'h9E37_79B9;
    endcase
  endfunction

  function automatic logic [31:0] pat_b(input int k);
    case (k)
      0: return 32'h0000_0000;  1: return 32'h0000_0001;
      2: return 32'h0101_0101;  3: return 32'h8080_8080;
      4: return 32'h1234_5678;  5: return 32'h5A5A_5A5A;
      6: return 32'h5A5A_5A5A;  7: return 32'h1122_1122;
      8: return 32'h1122_1122;  default: return 32'h7F4A_7C15;
    endcase
  endfunction

  task automatic model(input logic [31:0] a, input logic [31:0] b, input int op,
                       input int md, input int dst, input logic fen);
    int ng, w, nb, top;
    longint unsigned mask, av, bv, sm, rv;
    logic [31:0] r;
    logic [15:0] vf;
    logic cin;
    e_err = !(md != 3 && op < 6 && (md == 0 || dst < 8));
    if (e_err) return;
    ng = (md == 0) ? 1 : (md == 1) ? 2 : 4;
    w = 32 / ng;
    nb = w / 8;
    mask = (64'd1 << w) - 1;
    cin = |e_vf[15:12];
    r = '0;
    vf = '0;
    for (int g = 0; g < ng; g++) begin
      av = (longint'(a) >> (g * w)) & mask;
      bv = (longint'(b) >> (g * w)) & mask;
      if (op == 2) bv = (~bv) & mask;
      case (op)
        0: sm = av + bv;
        1: sm = av + bv + longint'(cin);
        2: sm = av + bv + 1;
        3: sm = av & bv;
        4: sm = av | bv;
        default: sm = av ^ bv;
      endcase
      rv = sm & mask;
      top = g * nb + nb - 1;
      if (op <= 2) begin
        vf[12+top] = ((sm >> w) & 1) != 0;
        vf[8+top] = (((~(av ^ bv)) & (av ^ rv)) >> (w - 1) & 1) != 0;
      end
      vf[4+top] = rv == 0;
      vf[top] = ((rv >> (w - 1)) & 1) != 0;
      r = r | 32'(rv << (g * w));
    end
    e_res = r;
    e_vf = vf;
    if (md == 0) e_eq = 1'b1;
    else if (md == 1) e_eq = r[31:16] == r[15:0];
    else e_eq = (r[31:24] == r[7:0]) && (r[23:16] == r[7:0]) && (r[15:8] == r[7:0]);
    e_irq = fen && !e_eq;
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input int op,
                        input int md, input int dst, input logic fen);
    logic [15:0] imask;
    @(negedge clk);
    opnd_a = a; opnd_b = b; op_code = 3'(op); lane_mode = 2'(md);
    dest_idx = 4'(dst); fault_en = fen; op_valid = 1'b1;
    model(a, b, op, md, dst, fen);
    @(negedge clk);
    op_valid = 1'b0;
    check(op == 1 ? "R10" : "R1", result, e_res);
    check("R2", 32'(vec_flags), 32'(e_vf));
    imask = (md == 0) ? 16'h7777 : (md == 1) ? 16'h5555 : 16'h0000;
    if (!e_err) check("R3", 32'(vec_flags & imask), 32'h0);
    check("R4", {28'd0, sum_c, sum_v, sum_z, sum_n},
          {28'd0, |e_vf[15:12], |e_vf[11:8], |e_vf[7:4], |e_vf[3:0]});
    check("R5", 32'(lanes_equal), 32'(e_eq));
    check("R6", 32'(fault_irq), 32'(e_irq));
    if (md != 0 && md != 3 && op < 6) check("R7", 32'(width_err), 32'(e_err));
    else check("R9", 32'(width_err), 32'(e_err));
    if (op >= 3 && op <= 5 && !e_err) check("R8", {30'd0, sum_c, sum_v}, 32'h0);
  endtask

  initial begin
    int dl[4] = '{0, 7, 8, 15};
    repeat (3) @(negedge clk);
    check("R11", result, 32'h0);
    check("R11", 32'(vec_flags), 32'h0);
    check("R11", {29'd0, lanes_equal, fault_irq, width_err}, 32'h4);
    rst_n = 1'b1;
    for (int op = 0; op < 8; op++)
      for (int md = 0; md < 4; md++)
        for (int d = 0; d < 4; d++)
          for (int k = 0; k < 10; k++)
            run_op(pat_a(k), pat_b(k), op, md, dl[d], 1'((k + op + d) & 1));
    run_op(32'hFFFF_FFFF, 32'h0000_0001, 0, 2, 0, 1'b1);
    run_op(32'h0000_0000, 32'h0000_0000, 1, 2, 0, 1'b1);
    run_op(32'h0000_0000, 32'h0000_0000, 1, 0, 9, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R1 watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule